// File: doc/BRIEF.md
# Deferred Interrupt Dispatch Unit

This unit sits between the interrupt sources and an instruction sequencer. At each instruction boundary it decides whether the sequencer enters the non-maskable interrupt (NMI), enters the maskable interrupt (IRQ), or runs the next instruction. An NMI request is not taken when it arrives. It is stamped with a due cycle a fixed number of cycles ahead and waits until the cycle count reaches that point. The IRQ is a level line. It goes high when the cycle count reaches a programmed timer position and stays high until the sequencer acknowledges it.

Requests to set or clear the interrupt-disable flag are held back. They take effect at the next boundary, just before the interrupt decision. As a result, the flag value saved with an interrupt is the new value. A wait state entered by a wait instruction ends when an interrupt becomes due. The unit then issues a wake strobe. That strobe tells the sequencer to step the program counter by one and to add a fixed cycle penalty.

The sequencer drives the cycle count. At each line wrap it rebases that count and pulses the wrap input. The unit then pulls both stored positions back by one line length, so they stay aligned with the count.

Top module: `intr_dispatch`

## Requirements
- R1: After reset, the disable flag reads 1, every strobe is 0, no NMI is pending and the IRQ timer is idle.
- R2: An NMI request stores the position cycle+NMI_DELAY (default 6). The NMI is taken at the first boundary where the cycle count is at or past that position, and at no boundary before it.
- R3: Taking an NMI clears its pending state and parks the position at the sentinel 0xFFFF. No second NMI follows without a new request.
- R4: The IRQ line goes high once the cycle count reaches the loaded timer position, and the timer then returns to the sentinel 0x0FFFFFFF. A timer at the sentinel never raises the line. The line stays high, and is taken again at later boundaries, until the acknowledge input clears it.
- R5: The IRQ is taken only if the resolved disable flag is 0. Taking either interrupt sets the flag to 1.
- R6: When an NMI and an IRQ are both due at one boundary, only the NMI is taken. The two take strobes are never high together.
- R7: In the wait state, a due NMI or a high IRQ line at a boundary produces one wake strobe with the wake cycle count WAKE_CYC (default 14), whatever the disable flag. The wake strobe also means the program counter steps by one.
- R8: Set and clear requests change the flag only at the next boundary. Clear wins over set. The push-flag output carries the resolved value used at that boundary.
- R9: A line wrap subtracts LINE_LEN (default 1364) from the NMI position and from the timer position. A position holding its sentinel is left unchanged.
- R10: Strobes appear only in the cycle after a boundary edge and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | CYC_W | Current cycle count within the line |
| boundary_i | input | 1 | Instruction boundary strobe |
| line_wrap_i | input | 1 | Line wrap strobe; positions move back one line |
| nmi_req_i | input | 1 | NMI request, due NMI_DELAY cycles later |
| tmr_load_i | input | 1 | Load IRQ timer position |
| tmr_pos_i | input | CYC_W | IRQ timer position to load |
| irq_ack_i | input | 1 | Clears the IRQ line |
| wai_i | input | 1 | Enter wait-for-interrupt state |
| iflag_set_i | input | 1 | Deferred request to set the disable flag |
| iflag_clr_i | input | 1 | Deferred request to clear the disable flag |
| take_nmi_o | output | 1 | Enter NMI |
| take_irq_o | output | 1 | Enter IRQ |
| wake_o | output | 1 | Leave wait state; program counter steps by one |
| wake_cyc_o | output | WAKE_W | Extra cycles to add on wake, 0 otherwise |
| push_flag_o | output | 1 | Resolved disable flag at the last boundary |
| iflag_o | output | 1 | Current disable flag |

## Verification
The decision is made from state that is already registered plus `cyc_i` in the boundary cycle. Every strobe, and the updated `iflag_o`, is therefore registered at the edge that samples `boundary_i` and is due exactly one cycle later.

Each bench task raises `boundary_i` on a falling edge and lowers it on the next falling edge. It samples the outputs at that second falling edge, which falls between the registering edge and the edge that clears the strobes. Timer and NMI due points are probed one count early and then at the exact position. Deferred flag requests are read back through `iflag_o` both before and after a boundary.

// File: rtl/intr_dispatch_pkg.sv
package intr_dispatch_pkg;
  typedef enum logic [1:0] {
    TAKE_NONE = 2'd0,
    TAKE_NMI  = 2'd1,
    TAKE_IRQ  = 2'd2
  } take_e;
endpackage

// File: rtl/idp_nmi_track.sv
module idp_nmi_track #(
  parameter int unsigned      CYC_W     = 32,
  parameter int unsigned      NMI_DELAY = 6,
  parameter int unsigned      LINE_LEN  = 1364,
  parameter logic [CYC_W-1:0] IDLE      = 'hFFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic             req_i,
  input  logic             take_i,
  input  logic             wrap_i,
  output logic             due_o
);
  localparam logic [CYC_W-1:0] DLY  = CYC_W'(NMI_DELAY);
  localparam logic [CYC_W-1:0] LINE = CYC_W'(LINE_LEN);

  logic             pend_q;
  logic [CYC_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      pos_q  <= IDLE;
    end else if (req_i) begin
      pend_q <= 1'b1;
      pos_q  <= cyc_i + DLY;
    end else if (take_i) begin
      pend_q <= 1'b0;
      pos_q  <= IDLE;
    end else if (wrap_i && pos_q != IDLE) begin
      pos_q  <= pos_q - LINE;
    end
  end

  assign due_o = pend_q && (cyc_i >= pos_q);

  // R2
  nmi_pend_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(req_i));
  // R3
  nmi_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !req_i) |=> (!pend_q && pos_q == IDLE));
endmodule

// File: rtl/idp_irq_timer.sv
module idp_irq_timer #(
  parameter int unsigned      CYC_W    = 32,
  parameter int unsigned      LINE_LEN = 1364,
  parameter logic [CYC_W-1:0] IDLE     = 'h0FFF_FFFF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CYC_W-1:0] cyc_i,
  input  logic             load_i,
  input  logic [CYC_W-1:0] pos_i,
  input  logic             ack_i,
  input  logic             wrap_i,
  output logic             line_o
);
  localparam logic [CYC_W-1:0] LINE = CYC_W'(LINE_LEN);

  logic [CYC_W-1:0] pos_q;
  logic             line_q;
  logic             hit;

  assign hit = (pos_q != IDLE) && (cyc_i >= pos_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= IDLE;
    end else if (load_i) begin
      pos_q <= pos_i;
    end else if (hit) begin
      pos_q <= IDLE;
    end else if (wrap_i && pos_q != IDLE) begin
      pos_q <= pos_q - LINE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    line_q <= 1'b0;
    else if (hit)   line_q <= 1'b1;
    else if (ack_i) line_q <= 1'b0;
  end

  assign line_o = line_q | hit;

  // R4
  irq_line_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(line_q) |-> $past(pos_q != IDLE));
  // R4
  irq_line_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_q && !ack_i) |=> line_q);
endmodule

// File: rtl/idp_iflag_defer.sv
module idp_iflag_defer (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic bnd_i,
  input  logic take_i,
  output logic new_o,
  output logic flag_o
);
  logic flag_q, pset_q, pclr_q;

  // clear has priority over set
  assign new_o = pclr_q ? 1'b0 : (pset_q ? 1'b1 : flag_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b1;
      pset_q <= 1'b0;
      pclr_q <= 1'b0;
    end else if (bnd_i) begin
      flag_q <= take_i ? 1'b1 : new_o;
      pset_q <= set_i;
      pclr_q <= clr_i;
    end else begin
      pset_q <= pset_q | set_i;
      pclr_q <= pclr_q | clr_i;
    end
  end

  assign flag_o = flag_q;

  // R8
  iflag_defer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bnd_i |=> (flag_q == $past(flag_q)));
endmodule

// File: rtl/intr_dispatch.sv
module intr_dispatch
  import intr_dispatch_pkg::*;
#(
  parameter int unsigned CYC_W     = 32,
  parameter int unsigned NMI_DELAY = 6,
  parameter int unsigned LINE_LEN  = 1364,
  parameter int unsigned WAKE_CYC  = 14,
  parameter int unsigned WAKE_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CYC_W-1:0]  cyc_i,
  input  logic              boundary_i,
  input  logic              line_wrap_i,
  input  logic              nmi_req_i,
  input  logic              tmr_load_i,
  input  logic [CYC_W-1:0]  tmr_pos_i,
  input  logic              irq_ack_i,
  input  logic              wai_i,
  input  logic              iflag_set_i,
  input  logic              iflag_clr_i,
  output logic              take_nmi_o,
  output logic              take_irq_o,
  output logic              wake_o,
  output logic [WAKE_W-1:0] wake_cyc_o,
  output logic              push_flag_o,
  output logic              iflag_o
);
  localparam logic [CYC_W-1:0]  NMI_IDLE = CYC_W'(32'h0000_FFFF);
  localparam logic [CYC_W-1:0]  TMR_IDLE = CYC_W'(32'h0FFF_FFFF);
  localparam logic [WAKE_W-1:0] WAKE_V   = WAKE_W'(WAKE_CYC);

  logic  nmi_due, irq_line, new_flag, waiting_q, wake_c;
  take_e dec;

  idp_nmi_track #(
    .CYC_W(CYC_W), .NMI_DELAY(NMI_DELAY), .LINE_LEN(LINE_LEN), .IDLE(NMI_IDLE)
  ) u_nmi (
    .clk_i, .rst_ni, .cyc_i,
    .req_i  (nmi_req_i),
    .take_i (dec == TAKE_NMI),
    .wrap_i (line_wrap_i),
    .due_o  (nmi_due)
  );

  idp_irq_timer #(
    .CYC_W(CYC_W), .LINE_LEN(LINE_LEN), .IDLE(TMR_IDLE)
  ) u_tmr (
    .clk_i, .rst_ni, .cyc_i,
    .load_i (tmr_load_i),
    .pos_i  (tmr_pos_i),
    .ack_i  (irq_ack_i),
    .wrap_i (line_wrap_i),
    .line_o (irq_line)
  );

  idp_iflag_defer u_flag (
    .clk_i, .rst_ni,
    .set_i  (iflag_set_i),
    .clr_i  (iflag_clr_i),
    .bnd_i  (boundary_i),
    .take_i (dec != TAKE_NONE),
    .new_o  (new_flag),
    .flag_o (iflag_o)
  );

  // NMI first, IRQ gated by the already-resolved flag
  always_comb begin
    dec = TAKE_NONE;
    if (boundary_i) begin
      if (nmi_due)                    dec = TAKE_NMI;
      else if (irq_line && !new_flag) dec = TAKE_IRQ;
    end
  end

  assign wake_c = boundary_i && waiting_q && (nmi_due || irq_line);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      waiting_q   <= 1'b0;
      take_nmi_o  <= 1'b0;
      take_irq_o  <= 1'b0;
      wake_o      <= 1'b0;
      wake_cyc_o  <= '0;
      push_flag_o <= 1'b1;
    end else begin
      take_nmi_o <= (dec == TAKE_NMI);
      take_irq_o <= (dec == TAKE_IRQ);
      wake_o     <= wake_c;
      wake_cyc_o <= wake_c ? WAKE_V : '0;
      if (boundary_i) push_flag_o <= new_flag;
      if (wake_c)     waiting_q <= 1'b0;
      else if (wai_i) waiting_q <= 1'b1;
    end
  end

  // R6
  one_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(take_nmi_o && take_irq_o));
  // R10
  take_on_bnd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_nmi_o || take_irq_o || wake_o) |-> $past(boundary_i));
  // R5
  irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> (!push_flag_o && iflag_o));
  // R7
  wake_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (wake_cyc_o == WAKE_V && !$past(wake_o)));
endmodule

// File: tb/intr_dispatch_bench.sv
module intr_dispatch_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cyc_i = '0;
  logic        boundary_i = 0, line_wrap_i = 0, nmi_req_i = 0, tmr_load_i = 0;
  logic [31:0] tmr_pos_i = '0;
  logic        irq_ack_i = 0, wai_i = 0, iflag_set_i = 0, iflag_clr_i = 0;
  logic        take_nmi_o, take_irq_o, wake_o, push_flag_o, iflag_o;
  logic [7:0]  wake_cyc_o;

  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  intr_dispatch u_intr_dispatch (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bnd(input logic [31:0] c);
    @(negedge clk_i); cyc_i = c; boundary_i = 1'b1;
    @(negedge clk_i); boundary_i = 1'b0;
  endtask

  task automatic nmi_at(input logic [31:0] c);
    @(negedge clk_i); cyc_i = c; nmi_req_i = 1'b1;
    @(negedge clk_i); nmi_req_i = 1'b0;
  endtask

  task automatic tmr_at(input logic [31:0] p);
    @(negedge clk_i); tmr_pos_i = p; tmr_load_i = 1'b1;
    @(negedge clk_i); tmr_load_i = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk_i); irq_ack_i = 1'b1;
    @(negedge clk_i); irq_ack_i = 1'b0;
  endtask

  task automatic req_flag(input logic s, input logic c);
    @(negedge clk_i); iflag_set_i = s; iflag_clr_i = c;
    @(negedge clk_i); iflag_set_i = 1'b0; iflag_clr_i = 1'b0;
  endtask

  task automatic wrap();
    @(negedge clk_i); line_wrap_i = 1'b1;
    @(negedge clk_i); line_wrap_i = 1'b0;
  endtask

  task automatic wai();
    @(negedge clk_i); wai_i = 1'b1;
    @(negedge clk_i); wai_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 iflag", iflag_o, 1);
    chk("R1 nmi", take_nmi_o, 0);
    chk("R1 irq", take_irq_o, 0);
    chk("R1 wake", wake_o, 0);
    req_flag(0, 1);
    chk("R8 deferred clr", iflag_o, 1);
    bnd(32'd10);
    chk("R8 clr applied", iflag_o, 0);
    bnd(32'h0FFF_FFFF);
    chk("R4 idle timer", take_irq_o, 0);
    chk("R1 no nmi pending", take_nmi_o, 0);
  endtask

  task automatic t_nmi();
    nmi_at(32'd100);
    bnd(32'd105);
    chk("R2 early", take_nmi_o, 0);
    @(negedge clk_i); cyc_i = 32'd106;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R10 no bnd", take_nmi_o, 0);
    end
    bnd(32'd106);
    chk("R2 due", take_nmi_o, 1);
    chk("R5 nmi sets flag", iflag_o, 1);
    @(negedge clk_i);
    chk("R10 one cycle", take_nmi_o, 0);
    bnd(32'd200);
    chk("R3 no repeat", take_nmi_o, 0);
  endtask

  task automatic t_irq();
    tmr_at(32'd500);
    bnd(32'd499);
    chk("R4 early", take_irq_o, 0);
    bnd(32'd500);
    chk("R5 masked", take_irq_o, 0);
    req_flag(0, 1);
    bnd(32'd500);
    chk("R8 irq after clr", take_irq_o, 1);
    chk("R8 push new", push_flag_o, 0);
    chk("R5 irq sets flag", iflag_o, 1);
    req_flag(0, 1);
    bnd(32'd510);
    chk("R4 level held", take_irq_o, 1);
    ack();
    req_flag(0, 1);
    bnd(32'd520);
    chk("R4 ack clears", take_irq_o, 0);
    chk("R8 flag clear", iflag_o, 0);
  endtask

  task automatic t_prio();
    tmr_at(32'd1000);
    nmi_at(32'd994);
    bnd(32'd1000);
    chk("R6 nmi first", take_nmi_o, 1);
    chk("R6 irq held", take_irq_o, 0);
    req_flag(0, 1);
    bnd(32'd1001);
    chk("R6 irq next", take_irq_o, 1);
    chk("R6 no nmi", take_nmi_o, 0);
    ack();
    req_flag(0, 1);
    bnd(32'd1002);
  endtask

  task automatic t_flag();
    req_flag(1, 1);
    bnd(32'd1100);
    chk("R8 clr beats set", iflag_o, 0);
    req_flag(1, 0);
    @(negedge clk_i);
    chk("R8 set deferred", iflag_o, 0);
    bnd(32'd1101);
    chk("R8 set applied", iflag_o, 1);
    chk("R8 push set", push_flag_o, 1);
  endtask

  task automatic t_wake();
    wai();
    @(negedge clk_i); cyc_i = 32'd2000;
    tmr_at(32'd2000);
    bnd(32'd2000);
    chk("R7 wake irq", wake_o, 1);
    chk("R7 wake cyc", wake_cyc_o, 14);
    chk("R7 masked no take", take_irq_o, 0);
    @(negedge clk_i);
    chk("R7 wake one shot", wake_o, 0);
    ack();
    wai();
    nmi_at(32'd3000);
    bnd(32'd3005);
    chk("R7 no early wake", wake_o, 0);
    bnd(32'd3006);
    chk("R7 wake nmi", wake_o, 1);
    chk("R7 nmi take", take_nmi_o, 1);
  endtask

  task automatic t_wrap();
    req_flag(0, 1);
    bnd(32'd3010);
    nmi_at(32'd1360);
    @(negedge clk_i); cyc_i = 32'd0;
    wrap();
    bnd(32'd1);
    chk("R9 nmi early", take_nmi_o, 0);
    bnd(32'd2);
    chk("R9 nmi shifted", take_nmi_o, 1);
    req_flag(0, 1);
    bnd(32'd2);
    tmr_at(32'd1400);
    @(negedge clk_i); cyc_i = 32'd0;
    wrap();
    bnd(32'd35);
    chk("R9 tmr early", take_irq_o, 0);
    bnd(32'd36);
    chk("R9 tmr shifted", take_irq_o, 1);
    ack();
    req_flag(0, 1);
    bnd(32'd40);
    wrap();
    bnd(32'h0FFF_FAAB);
    chk("R9 sentinel kept", take_irq_o, 0);
    bnd(32'h0FFF_FFFF);
    chk("R4 sentinel idle", take_irq_o, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=1 exp=0");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_nmi();
    t_irq();
    t_prio();
    t_flag();
    t_wake();
    t_wrap();
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule